// File: doc/BRIEF.md
# Variable-Length SPI Master with Register Interface

This block is a single-frame SPI master controlled through eight 16-bit registers. Software loads a 32-bit transmit word in two halves, with the data placed at the top of the word. It then writes a control word that sets the frame length (1 to 32 bits), the target device and the transfer kind. A write-only transfer only sends data. A read-write transfer also captures the slave's reply.

During a frame the block drives the serial clock, the serial output and one active-low select line. It samples the serial input. When the frame ends it sets a completion flag for the transfer kind that ran. Each completion flag can raise a shared interrupt, and each has its own mask. For a read-write frame, the reply sits at the bottom of a 32-bit receive word that software reads in two halves.

The register index is taken from address bits [3:1], so the registers sit at even byte offsets. Reads are combinational.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the select lines are all high, `spi_sclk`, `spi_mosi` and `irq` are low, and the registers read as follows: setup 2 reads 1, and every other register reads 0.
- R2: Register map by byte offset: 0x0 setup 1, 0x2 setup 2 (divider), 0x4 control, 0x6 status, 0x8 and 0xA transmit low and high halves, 0xC and 0xE receive low and high halves. Setup 1 keeps only bits 0 (clock enable), 4 (write-only interrupt mask) and 5 (read-write interrupt mask); its other bits read 0. The transmit halves read back what was written.
- R3: A control write with bit 0 set starts a read-write frame. With only bit 1 set it starts a write-only frame. With both bits set it starts a read-write frame. With neither bit set, no frame starts.
- R4: Control bits [6:2] hold N-1, and a frame has exactly N rising clock edges. The serial output sends the transmit word starting at bit 31 and moving down, whatever N is.
- R5: After a read-write frame of N bits, the receive word holds the N sampled bits in bits [N-1:0], with the first sampled bit highest, and all bits above them are 0.
- R6: A read-write frame sets status bit 0 at its end. A write-only frame sets status bit 1 and leaves the receive word unchanged.
- R7: Control bits [9:7] select the device. For index 0 to 4, that select line is low for the whole frame and the others stay high. For index 5 to 7, the frame runs with every select line high.
- R8: SPI mode 0: the clock idles low, the input is sampled on the rising edge, and the output changes only on the falling edge.
- R9: Each half period of the serial clock lasts D system clocks, where D is the setup 2 value; a value of 0 acts as 1.
- R10: Starting a frame clears both status flags. A control write that arrives while a frame is running, including in its last cycle, is ignored.
- R11: With setup 1 bit 0 clear, a control write starts nothing and the status is left as it was.
- R12: `irq` is high exactly when status bit 0 is set with setup 1 bit 5 clear, or when status bit 1 is set with setup 1 bit 4 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_DEV | Active-low device selects |
| irq | output | 1 | Interrupt request |

## Verification
A new control write can meet the cycle in which the current frame ends. In that cycle the engine is still busy, so the write must be dropped, and only a write one cycle later may start the next frame. The bench holds a control write on the bus for every cycle of an 8-bit frame at divider 1, up to one cycle past its last falling edge. It then counts the rising clock edges: exactly 12 (8 + 4) must appear. It also checks that the status and the control register show the second, write-only frame.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LEN_W  = 5;
    localparam int unsigned DEV_W  = 3;

    typedef enum logic [2:0] {
        RG_SETUP1 = 3'd0,
        RG_SETUP2 = 3'd1,
        RG_CTRL   = 3'd2,
        RG_STAT   = 3'd3,
        RG_TXL    = 3'd4,
        RG_TXH    = 3'd5,
        RG_RXL    = 3'd6,
        RG_RXH    = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/spi_rm_clkgen.sv
module spi_rm_clkgen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cg_t;

    cg_t q, d;
    logic [DIV_W-1:0] lim_m1;

    always_comb begin
        d      = q;
        lim_m1 = (div == '0) ? '0 : div - 1'b1;
        tick   = run && (q.cnt == lim_m1);
        if (!run || tick) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> q.cnt == '0); // R9

endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rw,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              done_rw
);
    typedef struct packed {
        logic              busy;
        logic              rw;
        logic              sclk;
        logic [LEN_W-1:0]  bitn;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.rw   = start_rw;
                d.sclk = 1'b0;
                d.bitn = '0;
                d.len  = start_len;
                d.tx   = tx_word;
                if (start_rw) d.rx = '0;
            end
        end else if (tick) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
                if (q.rw) d.rx = {q.rx[WORD_W-2:0], miso};
            end else begin
                d.sclk = 1'b0;
                d.tx   = {q.tx[WORD_W-2:0], 1'b0};
                if (q.bitn == q.len) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sclk    = q.sclk;
    assign mosi    = q.busy & q.tx[WORD_W-1];
    assign rx_word = q.rx;
    assign done_rw = q.rw;

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.bitn <= q.len); // R4
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sclk); // R8
    AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && tick && !q.sclk) |=> $stable(mosi)); // R8
    AST_RX_KEPT_WO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !q.rw) |=> $stable(q.rx)); // R6

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int unsigned NUM_DEV = 5,
    parameter int unsigned DIV_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         reg_addr,
    input  logic               reg_we,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [NUM_DEV-1:0] spi_cs_n,
    output logic               irq
);
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef struct packed {
        logic              clk_en;
        logic              wo_msk;
        logic              rw_msk;
        logic [DIV_W-1:0]  div;
        logic [LEN_W-1:0]  len;
        logic [DEV_W-1:0]  dev;
        logic [WORD_W-1:0] tx;
        logic              rw_done;
        logic              wo_done;
    } rf_t;

    rf_t q, d;
    reg_sel_e          sel;
    logic              ctrl_wr, start, start_rw;
    logic              busy, tick, done, done_rw;
    logic [WORD_W-1:0] rx_word;

    assign sel      = reg_sel_e'(reg_addr[3:1]);
    assign ctrl_wr  = reg_we && (sel == RG_CTRL);
    assign start_rw = reg_wdata[0];
    assign start    = ctrl_wr && !busy && q.clk_en && (reg_wdata[0] || reg_wdata[1]);

    always_comb begin
        d = q;
        if (reg_we) begin
            unique case (sel)
                RG_SETUP1: begin
                    d.clk_en = reg_wdata[0];
                    d.wo_msk = reg_wdata[4];
                    d.rw_msk = reg_wdata[5];
                end
                RG_SETUP2: d.div = reg_wdata[DIV_W-1:0];
                RG_TXL:    d.tx[HALF_W-1:0] = reg_wdata;
                RG_TXH:    d.tx[WORD_W-1:HALF_W] = reg_wdata;
                default:   ;
            endcase
        end
        if (start) begin
            d.len     = reg_wdata[6:2];
            d.dev     = reg_wdata[9:7];
            d.rw_done = 1'b0;
            d.wo_done = 1'b0;
        end
        if (done) begin
            if (done_rw) d.rw_done = 1'b1;
            else         d.wo_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (sel)
            RG_SETUP1: reg_rdata = {10'b0, q.rw_msk, q.wo_msk, 3'b0, q.clk_en};
            RG_SETUP2: reg_rdata = 16'(q.div);
            RG_CTRL:   reg_rdata = {6'b0, q.dev, q.len, 2'b00};
            RG_STAT:   reg_rdata = {14'b0, q.wo_done, q.rw_done};
            RG_TXL:    reg_rdata = q.tx[HALF_W-1:0];
            RG_TXH:    reg_rdata = q.tx[WORD_W-1:HALF_W];
            RG_RXL:    reg_rdata = rx_word[HALF_W-1:0];
            default:   reg_rdata = rx_word[WORD_W-1:HALF_W];
        endcase
    end

    assign irq = (q.rw_done && !q.rw_msk) || (q.wo_done && !q.wo_msk);

    spi_rm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (q.div),
        .tick  (tick)
    );

    spi_rm_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rw  (start_rw),
        .start_len (reg_wdata[6:2]),
        .tx_word   (q.tx),
        .tick      (tick),
        .miso      (spi_miso),
        .busy      (busy),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_word   (rx_word),
        .done      (done),
        .done_rw   (done_rw)
    );

    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_cs
        assign spi_cs_n[gi] = !(busy && (q.dev == DEV_W'(gi)));
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n)); // R7
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> &spi_cs_n); // R7
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!q.rw_done && !q.wo_done)); // R10
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> ($stable(q.len) && $stable(q.dev))); // R10
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.rw_done && q.wo_done)); // R6

endmodule

// File: tb/spi_regmaster_bench.sv
module spi_regmaster_bench;

    localparam int NDEV = 5;

    typedef struct packed {
        logic [4:0]  lc;
        logic [2:0]  dev;
        logic        rw;
        logic [31:0] tx;
        logic [31:0] sl;
        logic [15:0] div;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd7,  3'd0, 1'b1, 32'hA500_0000, 32'h3C00_0000, 16'd1},
        '{5'd0,  3'd1, 1'b1, 32'h8000_0000, 32'h8000_0000, 16'd2},
        '{5'd31, 3'd4, 1'b1, 32'h1234_5678, 32'hCAFE_F00D, 16'd1},
        '{5'd12, 3'd2, 1'b0, 32'hFFF8_0000, 32'h5555_5555, 16'd3},
        '{5'd16, 3'd7, 1'b1, 32'h0F0F_0000, 32'h9ABC_0000, 16'd0},
        '{5'd4,  3'd3, 1'b0, 32'h6800_0000, 32'hFFFF_FFFF, 16'd1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            spi_sclk, spi_mosi, spi_miso, irq;
    logic [NDEV-1:0] spi_cs_n;

    int          n_chk = 0;
    int          n_err = 0;
    int          edges = 0;
    logic [31:0] cap = '0;
    logic [31:0] slave = '0;
    logic [NDEV-1:0] cs_exp = '1;
    logic        cs_bad = 1'b0;
    time         t_rise = 0;
    time         half = 0;

    always #5 clk = ~clk;

    spi_regmaster u_spi_regmaster (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n),
        .irq       (irq)
    );

    assign spi_miso = slave[31];

    always @(posedge spi_sclk) begin
        edges++;
        cap = {cap[30:0], spi_mosi};
        if (spi_cs_n !== cs_exp) cs_bad = 1'b1;
        t_rise = $time;
    end

    always @(negedge spi_sclk) begin
        half  = $time - t_rise;
        slave = slave << 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output logic [15:0] st);
        st = '0;
        for (int i = 0; i < 4000 && st == 16'h0; i++) rd(4'h6, st);
    endtask

    function automatic logic [NDEV-1:0] cs_for(input logic [2:0] dev);
        return (dev < 3'(NDEV)) ? ~(NDEV'(1) << dev) : '1;
    endfunction

    function automatic logic [15:0] ctrl_word(input logic [4:0] lc, input logic [2:0] dev,
                                              input logic [1:0] kind);
        return {6'b0, dev, lc, kind};
    endfunction

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL WATCHDOG: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v, lo, hi, st;
        logic [31:0] prev_rx;
        int n;
        logic [31:0] mask;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 cs_n", 32'(spi_cs_n), 32'h1F);
        check("R1 sclk/mosi/irq", {29'b0, spi_sclk, spi_mosi, irq}, 32'h0);
        for (int a = 0; a < 16; a += 2) begin
            rd(4'(a), v);
            check("R1 register reset", 32'(v), (a == 2) ? 32'h1 : 32'h0);
        end

        // R2 readback
        wr(4'h0, 16'hFFFF); rd(4'h0, v); check("R2 setup1 bits", 32'(v), 32'h31);
        wr(4'h2, 16'h0003); rd(4'h2, v); check("R2 setup2", 32'(v), 32'h3);
        wr(4'h8, 16'hBEEF); wr(4'hA, 16'h1357);
        rd(4'h8, lo); rd(4'hA, hi); check("R2 tx halves", {hi, lo}, 32'h1357_BEEF);
        wr(4'h0, 16'h0001);

        // table of frames: R3 R4 R5 R6 R7 R8 R9
        prev_rx = '0;
        foreach (VECS[k]) begin
            n    = int'(VECS[k].lc) + 1;
            mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
            wr(4'h2, VECS[k].div);
            wr(4'h8, VECS[k].tx[15:0]);
            wr(4'hA, VECS[k].tx[31:16]);
            slave = VECS[k].sl; edges = 0; cap = '0; cs_bad = 1'b0;
            cs_exp = cs_for(VECS[k].dev);
            wr(4'h4, ctrl_word(VECS[k].lc, VECS[k].dev, VECS[k].rw ? 2'b01 : 2'b10));
            wait_done(st);
            repeat (2) @(negedge clk);
            check("R4 rising edge count", 32'(edges), 32'(n));
            check("R4 R8 mosi bits from bit 31", cap & mask, VECS[k].tx >> (32 - n));
            check("R7 chip select", 32'(cs_bad), 32'h0);
            check("R6 status flag", 32'(st), VECS[k].rw ? 32'h1 : 32'h2);
            check("R9 half period", 32'(half), (VECS[k].div == 0) ? 32'd10 : 32'(VECS[k].div) * 10);
            rd(4'hC, lo); rd(4'hE, hi);
            if (VECS[k].rw) begin
                prev_rx = VECS[k].sl >> (32 - n);
                check("R5 rx right-aligned", {hi, lo}, prev_rx);
            end else begin
                check("R6 rx unchanged by write-only", {hi, lo}, prev_rx);
            end
            check("R8 sclk idle low", 32'(spi_sclk), 32'h0);
        end

        // R11 clock enable off: nothing runs, status kept
        wr(4'h0, 16'h0000);
        edges = 0;
        wr(4'h4, ctrl_word(5'd3, 3'd0, 2'b01));
        repeat (30) @(negedge clk);
        check("R11 no edges when disabled", 32'(edges), 32'h0);
        rd(4'h6, v); check("R11 status kept", 32'(v), 32'h2);
        check("R11 cs_n idle", 32'(spi_cs_n), 32'h1F);

        // R3 neither start bit
        wr(4'h0, 16'h0001);
        wr(4'h4, ctrl_word(5'd3, 3'd0, 2'b00));
        repeat (30) @(negedge clk);
        check("R3 no start without command bit", 32'(edges), 32'h0);

        // R3 both bits -> read-write
        wr(4'h2, 16'd1);
        slave = 32'hF000_0000; cs_exp = cs_for(3'd1); cs_bad = 1'b0;
        wr(4'h4, ctrl_word(5'd3, 3'd1, 2'b11));
        wait_done(st);
        check("R3 both bits give read-write", 32'(st), 32'h1);
        rd(4'hC, lo); rd(4'hE, hi);
        check("R3 both bits capture rx", {hi, lo}, 32'hF);

        // R12 interrupt masking
        check("R12 irq on rw done unmasked", 32'(irq), 32'h1);
        wr(4'h0, 16'h0021); #1 check("R12 irq masked rw", 32'(irq), 32'h0);
        wr(4'h0, 16'h0011); #1 check("R12 irq with only wo masked", 32'(irq), 32'h1);

        // R10 flags cleared by start
        wr(4'h2, 16'd20);
        wr(4'h4, ctrl_word(5'd7, 3'd0, 2'b10));
        rd(4'h6, v); check("R10 flags cleared at start", 32'(v), 32'h0);
        wait_done(st);
        check("R6 wo flag", 32'(st), 32'h2);
        check("R12 irq masked wo", 32'(irq), 32'h0);
        wr(4'h0, 16'h0021); #1 check("R12 irq wo unmasked", 32'(irq), 32'h1);

        // R10 control write held across the end of a frame
        wr(4'h2, 16'd1);
        edges = 0; cs_bad = 1'b0; cs_exp = cs_for(3'd0);
        @(negedge clk);
        reg_addr = 4'h4; reg_wdata = ctrl_word(5'd7, 3'd0, 2'b01); reg_we = 1'b1;
        @(negedge clk);
        reg_wdata = ctrl_word(5'd3, 3'd0, 2'b10);
        repeat (17) @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        wait_done(st);
        repeat (2) @(negedge clk);
        check("R10 writes during busy ignored, edges", 32'(edges), 32'd12);
        check("R10 second frame is write-only", 32'(st), 32'h2);
        rd(4'h4, v); check("R10 control holds second length", 32'(v), 32'(ctrl_word(5'd3, 3'd0, 2'b00)));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule